// File: doc/BRIEF.md
# Command-Pointer I2C Target

This block is an I2C target that sits between a two-wire bus and a small register bank. After a START, the first byte carries a 7-bit device address and a read/write flag. On a write, the next byte is a command code. The block keeps that code in a pointer register, which it presents to the bank as the register address. Any bytes after the code are data. The command code decides how many data bytes are expected. The bank sees the whole write as one word with a single strobe, and only once the final expected byte has been acknowledged.

On a read, the block takes bytes from the bank's read port at the current pointer and sends them MSB first. The command code also decides how many meaningful bytes a read returns. The master ends a read with a NACK and then a STOP, or with a repeated START.

SCL and SDA are sampled with the system clock through two-flop synchronizers and edge-detected. The system clock must run at least 16 times faster than SCL. The block leaves the bus alone until its supply-good input has stayed high for a set number of clock cycles.

Top module: `i2c_cmd_target`

## Requirements
- R1: A falling SDA while SCL is high is a START and begins address reception. A rising SDA while SCL is high is a STOP; it returns the block to idle with SDA released, wherever the transfer stood.
- R2: The block changes from releasing SDA to pulling it low only while the synchronized SCL is low.
- R3: The block acknowledges the address byte only when its upper seven bits equal DEV_ADDR. On a mismatch it pulls SDA low for no bit until the next START, and the pointer and the write port do not change.
- R4: In a write transaction, the block acknowledges the first byte after the address and stores it in the pointer, which drives reg_addr. The pointer keeps its value across transactions and reads.
- R5: Bit 0 of the address byte fixes the direction for the whole transaction (1 = read). The bytes of a read transaction never load the pointer.
- R6: The number of write data bytes is set by pointer bits [7:6]: 00 gives 0, 01 gives 1, and 1x gives 2. Data bytes beyond that count get a NACK and are dropped.
- R7: wr_strobe pulses for one cycle when the acknowledge pulse of the last expected data byte closes. At that point wr_data holds the first data byte in [7:0] and the second in [15:8], and wr_count shows the expected count. A STOP or START before that point produces no strobe.
- R8: A read returns rd_data[7:0] as the first byte. It returns rd_data[15:8] as the second byte only when pointer bit 7 is 1. Every byte after the valid ones reads as 0xFF. Each byte is sent MSB first.
- R9: When the master answers a read byte with NACK, the block releases SDA and drives nothing more until a START.
- R10: No acknowledge and no SDA drive take place until pwr_good has been high for PG_DELAY consecutive cycles. A low pwr_good releases SDA on the next cycle and restarts the wait.
- R11: After reset, SDA is released, wr_strobe is low and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Supply-good indication |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 8 | Pointer (command code) to the register bank |
| rd_data | input | 16 | Read word at reg_addr, byte 0 in [7:0] |
| wr_data | output | 16 | Collected write data, byte 0 in [7:0] |
| wr_strobe | output | 1 | One-cycle commit pulse |
| wr_count | output | 2 | Number of data bytes the current command takes |

## Verification
Two events can land back to back on the same bus edge: the commit of a finished write, and the STOP or repeated START that follows it. Both hinge on the closing SCL fall of an acknowledge pulse. The bench sends a STOP right after the ninth pulse of a complete write and expects exactly one strobe carrying the right word. It also sends a STOP one byte early and expects no strobe at all. The same edge also decides the handover from an address acknowledge to driving the first read bit. That case is judged by comparing the bytes read after a repeated START with the values the bank presents at the stored pointer.

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target #(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         PG_DELAY = 100000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_good,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic [7:0]  reg_addr,
  input  logic [15:0] rd_data,
  output logic [15:0] wr_data,
  output logic        wr_strobe,
  output logic [1:0]  wr_count
);

  localparam int PGW = $clog2(PG_DELAY + 1);
  localparam logic [PGW-1:0] PG_MAX = PGW'(PG_DELAY);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_WDATA, S_RDATA, S_WAIT} st_t;

  st_t        st;
  logic [2:0] scl_q, sda_q;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [1:0] idx;
  logic       rw, commit, mnack;
  logic [PGW-1:0] pgc;

  wire scl_s = scl_q[1];
  wire scl_d = scl_q[2];
  wire sda_s = sda_q[1];
  wire sda_d = sda_q[2];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start = scl_s & scl_d & sda_d & ~sda_s;
  wire stop  = scl_s & scl_d & ~sda_d & sda_s;
  wire live  = (pgc == PG_MAX) & pwr_good;

  assign wr_count = (reg_addr[7:6] == 2'b00) ? 2'd0 : (reg_addr[7] ? 2'd2 : 2'd1);

  logic [7:0] txb;
  assign txb = (idx == 2'd0) ? rd_data[7:0] :
               (idx == 2'd1 && reg_addr[7]) ? rd_data[15:8] : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
      pgc   <= '0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      if (!pwr_good)          pgc <= '0;
      else if (pgc != PG_MAX) pgc <= pgc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; idx <= '0;
      rw <= 1'b0; commit <= 1'b0; mnack <= 1'b0;
      sda_oe <= 1'b0; reg_addr <= '0; wr_data <= '0; wr_strobe <= 1'b0;
    end else begin
      wr_strobe <= 1'b0;
      if (!live) begin
        st <= S_IDLE; sda_oe <= 1'b0; commit <= 1'b0;
      end else if (start) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0; commit <= 1'b0;
        idx <= '0; mnack <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE; sda_oe <= 1'b0; commit <= 1'b0;
      end else if (st != S_IDLE && st != S_WAIT) begin
        if (scl_rise) begin
          cnt <= cnt + 4'd1;
          if (st != S_RDATA && cnt < 4'd8) sh <= {sh[6:0], sda_s};
          if (st == S_RDATA && cnt == 4'd8) mnack <= sda_s;
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            case (st)
              S_ADDR:
                if (sh[7:1] == DEV_ADDR) begin sda_oe <= 1'b1; rw <= sh[0]; end
                else st <= S_IDLE;
              S_CMD: begin sda_oe <= 1'b1; reg_addr <= sh; end
              S_WDATA:
                if (idx < wr_count) begin
                  sda_oe <= 1'b1;
                  if (idx == 2'd0) wr_data[7:0] <= sh;
                  else             wr_data[15:8] <= sh;
                  if (idx == wr_count - 2'd1) commit <= 1'b1;
                  idx <= idx + 2'd1;
                end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            sda_oe <= 1'b0;
            case (st)
              S_ADDR:
                if (rw) begin
                  st <= S_RDATA; sh <= txb; sda_oe <= ~txb[7]; idx <= idx + 2'd1;
                end else st <= S_CMD;
              S_CMD: begin st <= S_WDATA; idx <= '0; end
              S_WDATA:
                if (commit) begin wr_strobe <= 1'b1; commit <= 1'b0; end
              S_RDATA:
                if (mnack) st <= S_WAIT;
                else begin
                  sh <= txb; sda_oe <= ~txb[7];
                  if (idx != 2'd3) idx <= idx + 2'd1;
                end
              default: ;
            endcase
          end else if (st == S_RDATA && cnt != 4'd0) begin
            sh <= {sh[6:0], 1'b0};
            sda_oe <= ~sh[6];
          end
        end
      end
    end
  end

  a_r10_gate_release: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !sda_oe);
  a_r2_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  a_r7_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);
  a_r7_strobe_counted: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> wr_count != 2'd0);
  a_r1_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && live) |=> (!sda_oe && st == S_IDLE));
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_WAIT) |-> !sda_oe);

endmodule

// File: tb/i2c_cmd_target_tb.sv
module i2c_cmd_target_tb;
  localparam logic [6:0] ADDR = 7'h2A;
  localparam int PGD = 400;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, pwr_good = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_strobe;
  logic [7:0] reg_addr;
  logic [15:0] rd_data, wr_data;
  logic [1:0] wr_count;
  wire sda_bus = sda_m & ~sda_oe;
  assign rd_data = {reg_addr ^ 8'hA5, reg_addr};

  i2c_cmd_target #(.DEV_ADDR(ADDR), .PG_DELAY(PGD)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .rd_data(rd_data), .wr_data(wr_data),
    .wr_strobe(wr_strobe), .wr_count(wr_count));

  int n_tests = 0, n_fail = 0, n_strobe = 0;
  logic [15:0] cap_data;
  logic [1:0] cap_cnt;
  logic [7:0] cap_addr;

  always @(negedge clk) if (wr_strobe) begin
    n_strobe++; cap_data = wr_data; cap_cnt = wr_count; cap_addr = reg_addr;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask
  task automatic i2c_start(); sda_m = 1; scl_m = 1; qw(); sda_m = 0; qw(); scl_m = 0; qw(); endtask
  task automatic i2c_rstart(); sda_m = 1; qw(); scl_m = 1; qw(); sda_m = 0; qw(); scl_m = 0; qw(); endtask
  task automatic i2c_stop(); sda_m = 0; qw(); scl_m = 1; qw(); sda_m = 1; qw(); qw(); endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(); scl_m = 1; qw(); qw(); scl_m = 0; qw();
    end
    sda_m = 1; qw(); scl_m = 1; qw(); ack = ~sda_bus; qw(); scl_m = 0; qw();
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl_m = 1; qw(); b[i] = sda_bus; qw(); scl_m = 0;
    end
    qw(); sda_m = ~give_ack; qw(); scl_m = 1; qw(); qw(); scl_m = 0; qw(); sda_m = 1;
  endtask

  task automatic t_reset();
    check("R11 sda_oe", sda_oe, 0);
    check("R11 wr_strobe", wr_strobe, 0);
    check("R11 pointer", reg_addr, 8'h00);
  endtask

  task automatic t_power_gate();
    logic a;
    pwr_good = 1; repeat (2) @(negedge clk);
    i2c_start(); wr_byte({ADDR, 1'b0}, a); i2c_stop();
    check("R10 ack before delay", a, 0);
    repeat (PGD) @(negedge clk);
    i2c_start(); wr_byte({ADDR, 1'b0}, a); i2c_stop();
    check("R10 ack after delay", a, 1);
    pwr_good = 0; repeat (3) @(negedge clk); pwr_good = 1;
    i2c_start(); wr_byte({ADDR, 1'b0}, a); i2c_stop();
    check("R10 wait restarted", a, 0);
    repeat (PGD) @(negedge clk);
  endtask

  task automatic t_write_two();
    logic a0, a1, a2, a3; int s0 = n_strobe;
    i2c_start(); wr_byte({ADDR, 1'b0}, a0); wr_byte(8'h85, a1);
    wr_byte(8'h11, a2); wr_byte(8'h22, a3); i2c_stop();
    check("R3 addr ack", a0, 1);
    check("R4 cmd ack", a1, 1);
    check("R6 data acks", {a2, a3}, 2'b11);
    check("R7 one strobe", n_strobe - s0, 1);
    check("R7 word", cap_data, 16'h2211);
    check("R7 count", cap_cnt, 2);
    check("R4 pointer", cap_addr, 8'h85);
    check("R1 released after stop", sda_oe, 0);
  endtask

  task automatic t_write_extra();
    logic a0, a1, a2, a3; int s0 = n_strobe;
    i2c_start(); wr_byte({ADDR, 1'b0}, a0); wr_byte(8'h4C, a1);
    wr_byte(8'h33, a2); wr_byte(8'h44, a3); i2c_stop();
    check("R6 first data ack", a2, 1);
    check("R6 extra byte nack", a3, 0);
    check("R7 one strobe", n_strobe - s0, 1);
    check("R7 low byte", cap_data[7:0], 8'h33);
    check("R7 count one", cap_cnt, 1);
  endtask

  task automatic t_ptr_only();
    logic a0, a1, a2; int s0 = n_strobe;
    i2c_start(); wr_byte({ADDR, 1'b0}, a0); wr_byte(8'h12, a1); wr_byte(8'h77, a2); i2c_stop();
    check("R4 cmd ack", a1, 1);
    check("R6 zero-length nack", a2, 0);
    check("R6 no strobe", n_strobe - s0, 0);
    check("R4 pointer", reg_addr, 8'h12);
  endtask

  task automatic t_partial();
    logic a0, a1, a2; int s0 = n_strobe;
    i2c_start(); wr_byte({ADDR, 1'b0}, a0); wr_byte(8'h90, a1); wr_byte(8'h55, a2); i2c_stop();
    check("R7 partial acked", a2, 1);
    check("R7 partial no strobe", n_strobe - s0, 0);
    check("R1 idle after stop", sda_oe, 0);
  endtask

  task automatic t_mismatch();
    logic a0, a1, a2; int s0 = n_strobe;
    i2c_start(); wr_byte(8'h26, a0); wr_byte(8'h40, a1); wr_byte(8'h01, a2); i2c_stop();
    check("R3 mismatch nack", a0, 0);
    check("R3 later bytes nack", {a1, a2}, 2'b00);
    check("R3 no strobe", n_strobe - s0, 0);
    check("R3 pointer kept", reg_addr, 8'h90);
  endtask

  task automatic t_read_two();
    logic a0, a1, a2; logic [7:0] b0, b1, b2;
    i2c_start(); wr_byte({ADDR, 1'b0}, a0); wr_byte(8'hC3, a1);
    i2c_rstart(); wr_byte({ADDR, 1'b1}, a2);
    rd_byte(1, b0); rd_byte(1, b1); rd_byte(0, b2);
    check("R9 released after nack", sda_oe, 0);
    i2c_stop();
    check("R5 read addr ack", a2, 1);
    check("R8 byte0", b0, 8'hC3);
    check("R8 byte1", b1, 8'h66);
    check("R8 beyond length", b2, 8'hFF);
    check("R5 pointer unchanged", reg_addr, 8'hC3);
  endtask

  task automatic t_read_one();
    logic a0, a1, a2; logic [7:0] b0, b1;
    i2c_start(); wr_byte({ADDR, 1'b0}, a0); wr_byte(8'h05, a1);
    i2c_rstart(); wr_byte({ADDR, 1'b1}, a2);
    rd_byte(1, b0); rd_byte(0, b1); i2c_stop();
    check("R8 single byte", b0, 8'h05);
    check("R8 pad 0xFF", b1, 8'hFF);
  endtask

  task automatic t_read_bare();
    logic a0; logic [7:0] b0;
    i2c_start(); wr_byte({ADDR, 1'b1}, a0); rd_byte(0, b0);
    check("R9 quiet after nack", sda_oe, 0);
    i2c_stop();
    check("R5 pointer persists", b0, 8'h05);
    check("R5 pointer not loaded", reg_addr, 8'h05);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_power_gate();
    t_write_two();
    t_write_extra();
    t_ptr_only();
    t_partial();
    t_mismatch();
    t_read_two();
    t_read_one();
    t_read_bare();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule